// File: doc/BRIEF.md
# Prioritized Contention Access Engine

This block decides which of several traffic classes may take the medium during the contention part of a superframe. The transmitter keeps one queue per access category. Each category runs its own random backoff in parallel with the others, following carrier-sense multiple access with collision avoidance. A category first waits out its own arbitration space, measured in idle slots. It then waits out a backoff drawn uniformly from its current contention window. Counting only advances on slot boundaries where the medium is sensed idle and the slot belongs to the contention region. Beacon-period and reserved slots are outside that region, so the counters freeze there.

When counting ends, the highest-priority ready category is the contender. It is granted only if its pending exchange fits in the contention time still left. Otherwise no grant is given, and the category stays ready for a later slot. Lower-priority categories that are ready on the same slot as a grant suffer an internal collision and back off again with a doubled window. A report at the end of the exchange either resets the winner's window (success) or doubles it up to the category's ceiling (failure). Frame assembly, acknowledgement formats and the PHY belong to other blocks.

Top module: `cont_access_engine`

## Requirements
- R1: After reset `gnt_valid` and `tx_active` are 0, and every category's window on `win_now` is 2^emin - 1, where emin is that category's `ecw_min` field.
- R2: A qualifying tick is a clock with `slot_tick`, `med_idle` and `in_cont` all high while `tx_active` is 0. A category is armed in the first clock in which its pending flag is seen while it is neither armed nor transmitting. With arbitration space A and drawn backoff B, it is granted on the (A+B+1)-th qualifying tick after arming, if it wins and fits. `gnt_valid` is high for exactly the one clock after that tick's edge.
- R3: The backoff is drawn uniformly from 0 to the current window W = 2^e - 1, where e = min(emin + stage, emax, MAX_EXP) and stage counts doublings since the last success. So a grant arrives between A+1 and A+W+1 qualifying ticks after arming.
- R4: A tick with `in_cont` high and `med_idle` low, while `tx_active` is 0, reloads an armed category's arbination-space count to A. Its backoff count is held.
- R5: Ticks with `in_cont` low, and any tick while `tx_active` is high, change no counter and give no grant.
- R6: Category index k has priority over every index below k. When several categories are ready on a granting tick, the highest index is granted. Every other ready category doubles its window, draws a new backoff and restarts its arbitration space.
- R7: A grant is given only if the contender's `xdur` field is less than or equal to `time_left`; equal counts as fitting. Otherwise nothing is granted on that tick, no category's state changes, and the contender stays ready.
- R8: `tx_active` rises with the grant and stays high until the clock in which `tx_done` is seen. No new grant is issued while it is high.
- R9: A `tx_done` with `tx_ok` 0 doubles the granted category's window, saturating at 2^min(emax, MAX_EXP) - 1. A `tx_done` with `tx_ok` 1 returns it to 2^emin - 1.
- R10: A category whose pending flag is low, and which is not transmitting, is disarmed and never granted. Raising the flag again re-arms it with its full arbitration space.
- R11: `gnt_cat` carries the index of the granted category whenever `gnt_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_pending | input | NCAT | Queue non-empty flag per category, bit k for category k |
| aifs_n | input | NCAT*AIFS_W | Arbitration space in slots, field k at [k*AIFS_W +: AIFS_W] |
| ecw_min | input | NCAT*EXP_W | Minimum window exponent per category |
| ecw_max | input | NCAT*EXP_W | Maximum window exponent per category |
| slot_tick | input | 1 | One-clock pulse at each slot boundary |
| med_idle | input | 1 | Carrier sense reports an idle medium |
| in_cont | input | 1 | Current slot belongs to the contention region |
| time_left | input | TIME_W | Contention time remaining |
| xdur | input | NCAT*TIME_W | Duration of each category's pending exchange |
| tx_done | input | 1 | One-clock end-of-exchange report |
| tx_ok | input | 1 | Exchange succeeded, qualifies `tx_done` |
| gnt_valid | output | 1 | One-clock grant pulse |
| gnt_cat | output | CAT_W | Granted category index |
| tx_active | output | 1 | An exchange is in progress |
| win_now | output | NCAT*CW_W | Current contention window per category |

## Verification
The sweep measures the exact tick count to a grant for every category and arbitration space. A design that counted off by one, or counted the arming clock, would miss each expected value. A busy slot in the middle of the arbitration space must push the grant back by the full space. A design that only froze there would grant two ticks early. Likewise, ticks outside the contention region and ticks during an exchange must leave the counters untouched. Ties between categories must go to the higher index and raise the loser's window to 1. A duration equal to the time left must still be granted, and a lower-priority ready category must not be touched while the contender is held back. Repeated failures must climb the window 1, 3, 7 and then stay at 7, one success must bring it back to the minimum, and random draws must stay inside the window yet vary.

// File: rtl/cae_pkg.sv
package cae_pkg;

   // per-category event bundle handed from the arbiter to each slot timer
   typedef struct packed {
      logic win;   // category takes the medium
      logic coll;  // internal collision with a higher category
      logic done;  // exchange finished
      logic ok;    // exchange result
   } cat_evt_t;

endpackage

// File: rtl/cae_lfsr.sv
module cae_lfsr #(
   parameter int unsigned W    = 16,
   parameter logic [W-1:0] SEED = W'(16'hACE1)
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] state
);

   initial begin
      assert (W == 16 || W == 24 || W == 32)
         else $error("cae_lfsr: width %0d has no tap set", W);
      assert (SEED != '0) else $error("cae_lfsr: seed must be non-zero");
   end

   logic [W-1:0] taps;

   generate
      if (W == 16) begin : g_w16
         assign taps = W'(16'hB400);
      end else if (W == 24) begin : g_w24
         assign taps = W'(24'hE10000);
      end else begin : g_w32
         assign taps = W'(32'h80200003);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= SEED;
      else if (state[0])
         state <= (state >> 1) ^ taps;
      else
         state <= state >> 1;
   end

endmodule

// File: rtl/cae_slot_timer.sv
module cae_slot_timer
   import cae_pkg::*;
#(
   parameter int unsigned AIFS_W  = 4,
   parameter int unsigned EXP_W   = 4,
   parameter int unsigned MAX_EXP = 10,
   localparam int unsigned CW_W   = MAX_EXP,
   localparam int unsigned ST_W   = $clog2(MAX_EXP + 2),
   localparam int unsigned SUM_W  = ((EXP_W > ST_W) ? EXP_W : ST_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pending,
   input  logic [AIFS_W-1:0] aifs_n,
   input  logic [EXP_W-1:0]  emin,
   input  logic [EXP_W-1:0]  emax,
   input  logic [CW_W-1:0]   rnd,
   input  logic              cnt_tick,
   input  logic              busy_tick,
   input  cat_evt_t          evt,
   output logic              ready,
   output logic [CW_W-1:0]   cw_val
);

   logic              armed;
   logic              in_tx;
   logic [ST_W-1:0]   stage;
   logic [AIFS_W-1:0] aifs_left;
   logic [CW_W-1:0]   bo_left;

   logic [EXP_W-1:0]  e_lim;
   logic [SUM_W-1:0]  e_try;
   logic [SUM_W-1:0]  e_cur;
   logic              can_grow;
   logic [ST_W-1:0]   stage_up;
   logic [CW_W-1:0]   cw_up;
   logic [CW_W:0]     pow2;

   // window exponent: minimum plus doublings, clamped by the ceiling
   always_comb begin
      e_lim    = (emax > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : emax;
      e_try    = SUM_W'(emin) + SUM_W'(stage);
      can_grow = e_try < SUM_W'(e_lim);
      e_cur    = can_grow ? e_try : SUM_W'(e_lim);
      pow2     = (CW_W + 1)'(1) << e_cur;
      cw_val   = CW_W'(pow2 - (CW_W + 1)'(1));
      stage_up = can_grow ? stage + 1'b1 : stage;
      cw_up    = can_grow ? {cw_val[CW_W-2:0], 1'b1} : cw_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         in_tx     <= 1'b0;
         stage     <= '0;
         aifs_left <= '0;
         bo_left   <= '0;
      end else if (in_tx) begin
         if (evt.done) begin
            in_tx <= 1'b0;
            armed <= 1'b0;
            stage <= evt.ok ? '0 : stage_up;
         end
      end else if (evt.win) begin
         in_tx <= 1'b1;
         armed <= 1'b0;
      end else if (!pending) begin
         armed <= 1'b0;
      end else if (!armed) begin
         armed     <= 1'b1;
         aifs_left <= aifs_n;
         bo_left   <= rnd & cw_val;
      end else if (evt.coll) begin
         stage     <= stage_up;
         aifs_left <= aifs_n;
         bo_left   <= rnd & cw_up;
      end else if (busy_tick) begin
         aifs_left <= aifs_n;
      end else if (cnt_tick) begin
         if (aifs_left != '0)
            aifs_left <= aifs_left - 1'b1;
         else if (bo_left != '0)
            bo_left <= bo_left - 1'b1;
      end
   end

   assign ready = armed && !in_tx && (aifs_left == '0) && (bo_left == '0);

   // R3
   bo_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $stable(emin) && $stable(emax)) |-> (bo_left <= cw_val));

   // R10
   disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pending && !in_tx && !evt.win) |=> !ready);

endmodule

// File: rtl/cae_arbiter.sv
module cae_arbiter
   import cae_pkg::*;
#(
   parameter int unsigned NCAT   = 4,
   parameter int unsigned TIME_W = 12,
   localparam int unsigned CAT_W = $clog2(NCAT)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   slot_tick,
   input  logic                   med_idle,
   input  logic                   in_cont,
   input  logic [TIME_W-1:0]      time_left,
   input  logic [NCAT*TIME_W-1:0] xdur,
   input  logic [NCAT-1:0]        ready,
   input  logic                   tx_done,
   input  logic                   tx_ok,
   output logic                   cnt_tick,
   output logic                   busy_tick,
   output cat_evt_t               evt [NCAT],
   output logic                   gnt_valid,
   output logic [CAT_W-1:0]       gnt_cat,
   output logic                   tx_active
);

   logic [CAT_W-1:0]  top_idx;
   logic              any_ready;
   logic [TIME_W-1:0] top_dur;
   logic              fits;
   logic              do_grant;
   logic [NCAT-1:0]   win_vec;
   logic [NCAT-1:0]   coll_vec;
   logic [TIME_W-1:0] sel_dur;

   // highest ready index is the contender
   always_comb begin
      top_idx   = '0;
      any_ready = 1'b0;
      for (int i = 0; i < NCAT; i++) begin
         if (ready[i]) begin
            top_idx   = CAT_W'(i);
            any_ready = 1'b1;
         end
      end
   end

   assign top_dur   = xdur[top_idx*TIME_W +: TIME_W];
   assign fits      = top_dur <= time_left;
   assign cnt_tick  = slot_tick && med_idle && in_cont && !tx_active;
   assign busy_tick = slot_tick && !med_idle && in_cont && !tx_active;
   assign do_grant  = cnt_tick && any_ready && fits;
   assign win_vec   = do_grant ? (NCAT'(1) << top_idx) : '0;
   assign coll_vec  = do_grant ? (ready & ~win_vec) : '0;

   generate
      for (genvar c = 0; c < NCAT; c++) begin : g_evt
         assign evt[c].win  = win_vec[c];
         assign evt[c].coll = coll_vec[c];
         assign evt[c].done = tx_done && tx_active;
         assign evt[c].ok   = tx_ok;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_active <= 1'b0;
         gnt_valid <= 1'b0;
         gnt_cat   <= '0;
      end else begin
         gnt_valid <= do_grant;
         if (do_grant) begin
            tx_active <= 1'b1;
            gnt_cat   <= top_idx;
         end else if (tx_done) begin
            tx_active <= 1'b0;
         end
      end
   end

   // duration of the actual winner, muxed from the one-hot grant vector
   always_comb begin
      sel_dur = '0;
      for (int i = 0; i < NCAT; i++)
         if (win_vec[i]) sel_dur = sel_dur | xdur[i*TIME_W +: TIME_W];
   end

   // R7
   fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|win_vec) |-> (sel_dur <= time_left));

   // R6
   one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win_vec));

   // R6
   loser_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|coll_vec) |-> (coll_vec < win_vec));

   // R8
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> !$past(tx_active));

   // R2
   grant_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> $past(slot_tick && med_idle && in_cont));

endmodule

// File: rtl/cont_access_engine.sv
module cont_access_engine
   import cae_pkg::*;
#(
   parameter int unsigned NCAT    = 4,
   parameter int unsigned AIFS_W  = 4,
   parameter int unsigned EXP_W   = 4,
   parameter int unsigned MAX_EXP = 10,
   parameter int unsigned TIME_W  = 12,
   parameter int unsigned LFSR_W  = 16,
   localparam int unsigned CAT_W  = $clog2(NCAT),
   localparam int unsigned CW_W   = MAX_EXP
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NCAT-1:0]        q_pending,
   input  logic [NCAT*AIFS_W-1:0] aifs_n,
   input  logic [NCAT*EXP_W-1:0]  ecw_min,
   input  logic [NCAT*EXP_W-1:0]  ecw_max,
   input  logic                   slot_tick,
   input  logic                   med_idle,
   input  logic                   in_cont,
   input  logic [TIME_W-1:0]      time_left,
   input  logic [NCAT*TIME_W-1:0] xdur,
   input  logic                   tx_done,
   input  logic                   tx_ok,
   output logic                   gnt_valid,
   output logic [CAT_W-1:0]       gnt_cat,
   output logic                   tx_active,
   output logic [NCAT*CW_W-1:0]   win_now
);

   localparam int unsigned ROT = LFSR_W / NCAT;

   initial begin
      assert (NCAT >= 2) else $error("cont_access_engine: need two or more categories");
      assert (MAX_EXP >= 2 && MAX_EXP < (1 << EXP_W))
         else $error("cont_access_engine: MAX_EXP out of range for EXP_W");
      assert (LFSR_W >= CW_W) else $error("cont_access_engine: LFSR narrower than window");
   end

   logic [LFSR_W-1:0] lfsr;
   logic [NCAT-1:0]   ready;
   logic              cnt_tick;
   logic              busy_tick;
   cat_evt_t          evt [NCAT];

   cae_lfsr #(.W(LFSR_W), .SEED(LFSR_W'(16'hACE1))) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .state (lfsr)
   );

   generate
      for (genvar c = 0; c < NCAT; c++) begin : g_cat
         logic [LFSR_W-1:0] rot;
         logic [CW_W-1:0]   rnd;
         logic [CW_W-1:0]   cw_c;

         // each category sees a differently rotated, folded copy of the LFSR
         always_comb begin
            rot = (lfsr >> (c * ROT)) | (lfsr << (LFSR_W - c * ROT));
            rnd = '0;
            for (int k = 0; k < LFSR_W; k++)
               rnd[k % CW_W] = rnd[k % CW_W] ^ rot[k];
         end

         cae_slot_timer #(
            .AIFS_W  (AIFS_W),
            .EXP_W   (EXP_W),
            .MAX_EXP (MAX_EXP)
         ) u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .pending   (q_pending[c]),
            .aifs_n    (aifs_n[c*AIFS_W +: AIFS_W]),
            .emin      (ecw_min[c*EXP_W +: EXP_W]),
            .emax      (ecw_max[c*EXP_W +: EXP_W]),
            .rnd       (rnd),
            .cnt_tick  (cnt_tick),
            .busy_tick (busy_tick),
            .evt       (evt[c]),
            .ready     (ready[c]),
            .cw_val    (cw_c)
         );

         assign win_now[c*CW_W +: CW_W] = cw_c;
      end
   endgenerate

   cae_arbiter #(.NCAT(NCAT), .TIME_W(TIME_W)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_tick (slot_tick),
      .med_idle  (med_idle),
      .in_cont   (in_cont),
      .time_left (time_left),
      .xdur      (xdur),
      .ready     (ready),
      .tx_done   (tx_done),
      .tx_ok     (tx_ok),
      .cnt_tick  (cnt_tick),
      .busy_tick (busy_tick),
      .evt       (evt),
      .gnt_valid (gnt_valid),
      .gnt_cat   (gnt_cat),
      .tx_active (tx_active)
   );

   // R11
   cat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> (gnt_cat < NCAT));

endmodule

// File: tb/cont_access_engine_test.sv
`timescale 1ns/1ps
module cont_access_engine_test;

   localparam int NCAT = 4, AW = 4, EW = 4, MX = 10, TW = 12, CW = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCAT-1:0] q_pending = '0;
   logic [NCAT*AW-1:0] aifs_n;
   logic [NCAT*EW-1:0] ecw_min, ecw_max;
   logic slot_tick = 1'b0, med_idle = 1'b1, in_cont = 1'b1;
   logic [TW-1:0] time_left = TW'(1000);
   logic [NCAT*TW-1:0] xdur;
   logic tx_done = 1'b0, tx_ok = 1'b0;
   logic gnt_valid, tx_active;
   logic [1:0] gnt_cat;
   logic [NCAT*CW-1:0] win_now;

   logic [AW-1:0] a_cfg [NCAT];
   logic [EW-1:0] mn_cfg [NCAT];
   logic [EW-1:0] mx_cfg [NCAT];
   logic [TW-1:0] d_cfg [NCAT];

   always_comb
      for (int i = 0; i < NCAT; i++) begin
         aifs_n[i*AW +: AW]  = a_cfg[i];
         ecw_min[i*EW +: EW] = mn_cfg[i];
         ecw_max[i*EW +: EW] = mx_cfg[i];
         xdur[i*TW +: TW]    = d_cfg[i];
      end

   cont_access_engine uut (.*);

   always #10 clk = ~clk;

   int n_chk = 0, n_fail = 0;

   task automatic chk_eq(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_rng(string tag, int act, int lo, int hi);
      n_chk++;
      if (act < lo || act > hi) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
      end
   endtask

   function automatic int cw_of(int c);
      return int'(win_now[c*CW +: CW]);
   endfunction

   task automatic do_reset();
      q_pending = '0; slot_tick = 0; med_idle = 1; in_cont = 1;
      tx_done = 0; tx_ok = 0; time_left = TW'(1000);
      @(negedge clk); rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic default_cfg();
      for (int i = 0; i < NCAT; i++) begin
         a_cfg[i] = '0; mn_cfg[i] = '0; mx_cfg[i] = EW'(3); d_cfg[i] = TW'(10);
      end
   endtask

   task automatic do_tick(input bit idle, input bit cont);
      @(negedge clk);
      slot_tick = 1; med_idle = idle; in_cont = cont;
      @(negedge clk);
      slot_tick = 0; med_idle = 1; in_cont = 1;
   endtask

   task automatic finish_tx(input bit ok);
      @(negedge clk); tx_done = 1; tx_ok = ok;
      @(negedge clk); tx_done = 0; tx_ok = 0;
   endtask

   task automatic wait_grant(output int n);
      n = 0;
      for (int k = 1; k <= 40; k++) begin
         do_tick(1, 1);
         if (gnt_valid) begin n = k; break; end
      end
   endtask

   bit done_flag = 0;

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int n;
      int seen_lo, seen_hi;
      default_cfg();
      // R1: reset state and windows from the minimum exponents
      mn_cfg[0] = 3; mn_cfg[1] = 1; mn_cfg[2] = 2; mn_cfg[3] = 0;
      for (int i = 0; i < NCAT; i++) mx_cfg[i] = 5;
      do_reset();
      chk_eq("R1 gnt_valid", gnt_valid, 0);
      chk_eq("R1 tx_active", tx_active, 0);
      chk_eq("R1 win cat0", cw_of(0), 7);
      chk_eq("R1 win cat1", cw_of(1), 1);
      chk_eq("R1 win cat2", cw_of(2), 3);
      chk_eq("R1 win cat3", cw_of(3), 0);

      // R2 / R11: exact grant tick sweep over category and arbitration space
      default_cfg();
      do_reset();
      for (int c = 0; c < NCAT; c++)
         for (int a = 0; a <= 4; a++) begin
            a_cfg[c] = AW'(a);
            q_pending[c] = 1;
            wait_grant(n);
            q_pending[c] = 0;
            chk_eq($sformatf("R2 ticks cat%0d aifs%0d", c, a), n, a + 1);
            chk_eq("R11 gnt_cat", int'(gnt_cat), c);
            @(negedge clk);
            chk_eq("R2 pulse one clock", gnt_valid, 0);
            finish_tx(1);
            chk_eq("R8 released", tx_active, 0);
            a_cfg[c] = '0;
         end

      // R8: no grant while an exchange is active; tick during it is ignored (R5)
      do_reset();
      q_pending[0] = 1;
      wait_grant(n);
      chk_eq("R8 first grant", n, 1);
      q_pending[0] = 0; q_pending[1] = 1;
      for (int k = 0; k < 3; k++) begin
         do_tick(1, 1);
         chk_eq("R8 no grant while active", gnt_valid, 0);
      end
      chk_eq("R8 active held", tx_active, 1);
      finish_tx(1);
      wait_grant(n);
      chk_eq("R8 next grant ticks", n, 1);
      chk_eq("R11 next cat", int'(gnt_cat), 1);
      q_pending = '0;
      finish_tx(1);

      // R4: busy slot reloads the arbitration space
      do_reset();
      a_cfg[2] = 3;
      q_pending[2] = 1;
      do_tick(1, 1); do_tick(1, 1); do_tick(0, 1);
      chk_eq("R4 no grant on busy", gnt_valid, 0);
      wait_grant(n);
      chk_eq("R4 ticks after busy", n, 4);
      q_pending = '0;
      finish_tx(1);

      // R5: ticks outside contention are ignored
      do_reset();
      a_cfg[1] = 1;
      q_pending[1] = 1;
      for (int k = 0; k < 5; k++) begin
         do_tick(1, 0);
         chk_eq("R5 frozen outside contention", gnt_valid, 0);
      end
      wait_grant(n);
      chk_eq("R5 ticks after freeze", n, 2);
      q_pending = '0;
      finish_tx(1);

      // R6: priority and internal collision
      default_cfg();
      do_reset();
      a_cfg[0] = 1; a_cfg[3] = 1;
      q_pending[0] = 1; q_pending[3] = 1;
      wait_grant(n);
      chk_eq("R6 tie ticks", n, 2);
      chk_eq("R6 higher index wins", int'(gnt_cat), 3);
      chk_eq("R6 loser window doubled", cw_of(0), 1);
      chk_eq("R6 winner window", cw_of(3), 0);
      q_pending[3] = 0;
      finish_tx(1);
      wait_grant(n);
      chk_rng("R3 loser redraw ticks", n, 2, 3);
      chk_eq("R6 loser granted later", int'(gnt_cat), 0);
      q_pending = '0;
      finish_tx(1);
      // three-way tie
      default_cfg();
      do_reset();
      q_pending[2:0] = 3'b111;
      wait_grant(n);
      chk_eq("R6 three-way winner", int'(gnt_cat), 2);
      chk_eq("R6 cat1 doubled", cw_of(1), 1);
      chk_eq("R6 cat0 doubled", cw_of(0), 1);
      q_pending = '0;
      finish_tx(1);

      // R7: fit check against remaining time, lower ready category untouched
      default_cfg();
      do_reset();
      d_cfg[2] = 100; d_cfg[1] = 5;
      time_left = TW'(50);
      q_pending[2] = 1; q_pending[1] = 1;
      for (int k = 0; k < 3; k++) begin
         do_tick(1, 1);
         chk_eq("R7 withheld", gnt_valid, 0);
      end
      chk_eq("R7 lower untouched", cw_of(1), 0);
      time_left = TW'(100);
      do_tick(1, 1);
      chk_eq("R7 equal fits", gnt_valid, 1);
      chk_eq("R7 contender granted", int'(gnt_cat), 2);
      chk_eq("R6 lower collided", cw_of(1), 1);
      q_pending = '0;
      finish_tx(1);
      time_left = TW'(1000);

      // R9: failure doubling with ceiling, success reset
      default_cfg();
      do_reset();
      mn_cfg[1] = 1; mx_cfg[1] = 3; a_cfg[1] = 1;
      q_pending[1] = 1;
      wait_grant(n);
      chk_rng("R3 window 1", n, 2, 3);
      finish_tx(0);
      chk_eq("R9 fail to 3", cw_of(1), 3);
      wait_grant(n);
      chk_rng("R3 window 3", n, 2, 5);
      finish_tx(0);
      chk_eq("R9 fail to 7", cw_of(1), 7);
      wait_grant(n);
      chk_rng("R3 window 7", n, 2, 9);
      finish_tx(0);
      chk_eq("R9 capped at 7", cw_of(1), 7);
      wait_grant(n);
      chk_rng("R3 capped draw", n, 2, 9);
      q_pending = '0;
      finish_tx(1);
      chk_eq("R9 success to min", cw_of(1), 1);

      // R10: dropping the pending flag disarms; re-raising restarts
      default_cfg();
      do_reset();
      a_cfg[0] = 2;
      q_pending[0] = 1;
      do_tick(1, 1);
      q_pending[0] = 0;
      for (int k = 0; k < 5; k++) do_tick(1, 1);
      chk_eq("R10 no grant when idle", gnt_valid, 0);
      chk_eq("R10 no exchange", tx_active, 0);
      q_pending[0] = 1;
      wait_grant(n);
      chk_eq("R10 full space after rearm", n, 3);
      q_pending = '0;
      finish_tx(1);

      // R3: draws stay inside the window and vary
      default_cfg();
      do_reset();
      mn_cfg[3] = 2; mx_cfg[3] = 2;
      q_pending[3] = 1;
      seen_lo = 99; seen_hi = 0;
      for (int t = 0; t < 40; t++) begin
         wait_grant(n);
         chk_rng("R3 draw in window", n, 1, 4);
         if (n < seen_lo) seen_lo = n;
         if (n > seen_hi) seen_hi = n;
         if (t == 39) q_pending = '0;
         finish_tx(1);
      end
      n_chk++;
      if (seen_hi == seen_lo) begin
         n_fail++;
         $display("FAIL R3 draws vary actual=%0d..%0d expected=spread", seen_lo, seen_hi);
      end

      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule